// File: doc/BRIEF.md
# Command-Latched Register Access Port

This block is the host-facing register port of a network controller that sits on a 16-bit asynchronous bus. The bus has two select strobes. One opens a command port, the other a data port, and they share the read and write strobes. The host never places a register address on the bus during a data cycle. It first writes a command word that names the register offset and the byte lanes. The next data-port access then reads or writes that 16-bit register. Each command serves exactly one data access.

All bus strobes are brought into the core clock through two flip-flops. An access takes effect when its strobe is released. The register set holds a read-only identification word, a soft-reset control bit, an interrupt enable mask, an interrupt status word whose bits are set by core events and cleared by writing ones, and a small bank of general read/write words. Any other offset reads as zero and ignores writes.

Top module: `cmdlatch_regport`

## Requirements
- R1: After reset, `soft_rst` and `irq` are 0, and a data-port read with no command written since reset returns 0.
- R2: A command word holds the byte offset in bits 11..0 and lane flags in bits 15..12. The command is accepted only if offset bit 0 is 0 and the lane flags equal 4'b0011 when offset bit 1 is 0, or 4'b1100 when offset bit 1 is 1. Otherwise the next data access is ignored and reads return 0.
- R3: Each command serves one data access. A second data read without a new command returns 0, and a data write without a new command changes nothing.
- R4: Offset 0x0C0 reads 16'h8870 with the parameter REV in bits 3..1 (16'h8872 for REV=1). Writes to it have no effect.
- R5: Bit 0 of offset 0x026 drives `soft_rst` and stays set until software writes 0 there. The other bits of that register read 0.
- R6: Offset 0x092 is the interrupt status word. A 1 on `evt_i[n]` for one clock sets bit n. Writing a 1 clears the bit, and writing a 0 leaves it alone. When a set and a clear of the same bit fall in the same clock, the set wins. Bit 13 marks a received frame and bit 14 marks a finished transmit.
- R7: Offset 0x090 is a read/write enable mask. `irq` is 1 exactly when some status bit and its mask bit are both 1, so writing 0 to the mask silences `irq`.
- R8: Offsets 0x010, 0x012 and 0x014 are plain read/write words (NADR=3 from ADR_BASE). Any other offset reads 0 and ignores writes.
- R9: A strobe counts as one access however long it is held. Its register update happens at the third rising clock edge after the strobe is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_sel_n | input | 1 | Command port select, active low |
| dat_sel_n | input | 1 | Data port select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 16 | Write data; held by the host until the access takes effect |
| rdata | output | 16 | Read data of the selected register |
| evt_i | input | 16 | Core event pulses that set status bits |
| soft_rst | output | 1 | Global soft reset request |
| irq | output | 1 | Interrupt request, active high |

## Verification
A write takes effect at the third rising edge after its strobe is released: two edges for the synchroniser and one for the register update. The bench therefore waits four edges after each release before it issues the next access. One check samples `soft_rst` on the negative edge just before and just after that third edge, to pin the latency exactly. Read data is combinational from the latched command, so read checks sample mid-cycle while the read strobe is held. Event pulses are registered in one edge, and the set-over-clear case aligns the pulse with the third edge after a clearing write's release.

// File: rtl/cmdlatch_regport.sv
module cmdlatch_regport #(
  parameter logic [2:0]  REV      = 3'd1,
  parameter int          NADR     = 3,
  parameter logic [11:0] ADR_BASE = 12'h010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_sel_n,
  input  logic        dat_sel_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic [15:0] evt_i,
  output logic        soft_rst,
  output logic        irq
);
  localparam logic [11:0] OFS_ID  = 12'h0C0;
  localparam logic [11:0] OFS_GRR = 12'h026;
  localparam logic [11:0] OFS_IER = 12'h090;
  localparam logic [11:0] OFS_ISR = 12'h092;
  localparam logic [15:0] ID_VAL  = 16'h8870 | {12'h000, REV, 1'b0};

  // strobe bits: [0] command write, [1] data write, [2] data read
  logic [2:0] act, s1, s2, s3, fin;
  assign act = {~dat_sel_n & ~rd_n, ~dat_sel_n & ~wr_n, ~cmd_sel_n & ~wr_n};
  assign fin = s3 & ~s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {act, s1, s2};

  logic [15:0] cmd_q;
  logic        cmd_vld;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_q   <= '0;
      cmd_vld <= 1'b0;
    end else if (fin[0]) begin
      cmd_q   <= wdata;
      cmd_vld <= 1'b1;
    end else if (fin[1] | fin[2]) begin
      cmd_vld <= 1'b0;
    end

  logic [11:0] ofs;
  logic [3:0]  be;
  logic        hit, wr_go;
  assign ofs   = cmd_q[11:0];
  assign be    = cmd_q[15:12];
  assign hit   = cmd_vld && !ofs[0] && (be == (ofs[1] ? 4'b1100 : 4'b0011));
  assign wr_go = fin[1] && hit;

  logic        grr_q;
  logic [15:0] ier_q, isr_q, clr_mask;
  logic [15:0] adr_q [NADR];
  logic [NADR-1:0] adr_hit;

  for (genvar g = 0; g < NADR; g++) begin : g_adr
    assign adr_hit[g] = (ofs == ADR_BASE + 12'(2 * g));
  end

  assign clr_mask = (wr_go && ofs == OFS_ISR) ? wdata : 16'h0000;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      grr_q <= 1'b0;
      ier_q <= '0;
      isr_q <= '0;
      for (int i = 0; i < NADR; i++) adr_q[i] <= '0;
    end else begin
      isr_q <= (isr_q & ~clr_mask) | evt_i;
      if (wr_go && ofs == OFS_GRR) grr_q <= wdata[0];
      if (wr_go && ofs == OFS_IER) ier_q <= wdata;
      for (int i = 0; i < NADR; i++)
        if (wr_go && adr_hit[i]) adr_q[i] <= wdata;
    end

  logic [15:0] rd_val, adr_rd;
  always_comb begin
    adr_rd = '0;
    for (int i = 0; i < NADR; i++)
      if (adr_hit[i]) adr_rd = adr_rd | adr_q[i];
    if      (ofs == OFS_ID)  rd_val = ID_VAL;
    else if (ofs == OFS_GRR) rd_val = {15'h0000, grr_q};
    else if (ofs == OFS_IER) rd_val = ier_q;
    else if (ofs == OFS_ISR) rd_val = isr_q;
    else                     rd_val = adr_rd;
  end

  assign rdata    = hit ? rd_val : 16'h0000;
  assign soft_rst = grr_q;
  assign irq      = |(isr_q & ier_q);

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (fin != 3'b000) |=> (fin == 3'b000)); // R9
  AST_CMD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    fin[0] |=> cmd_vld); // R2
  AST_CMD_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    ((fin[1] | fin[2]) && !fin[0]) |=> !cmd_vld); // R3
  AST_SOFT_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fin[1] |=> $stable(soft_rst)); // R5
  AST_ISR_NO_SPONT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == 16'h0000) |=> ((isr_q & ~$past(isr_q)) == 16'h0000)); // R6
endmodule

// File: tb/cmdlatch_regport_tb_top.sv
module cmdlatch_regport_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_sel_n = 1'b1, dat_sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] wdata = '0, evt_i = '0;
  logic [15:0] rdata;
  logic soft_rst, irq;

  always #4 clk = ~clk;

  cmdlatch_regport dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_sel_n(cmd_sel_n), .dat_sel_n(dat_sel_n),
    .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .rdata(rdata),
    .evt_i(evt_i), .soft_rst(soft_rst), .irq(irq)
  );

  typedef struct {
    int          kind;  // 0 rdata, 1 soft_rst, 2 irq
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  logic  mon_req = 1'b0;
  int    n_cmp = 0, n_bad = 0, cycles = 0;

  always @(negedge clk) begin
    if (mon_req && exp_q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = exp_q.pop_front();
      case (it.kind)
        0:       act = rdata;
        1:       act = {15'h0, soft_rst};
        default: act = {15'h0, irq};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic chk(input int kind, input logic [15:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    mon_req = 1'b1;
    @(posedge clk); #1 mon_req = 1'b0;
  endtask

  task automatic release_all();
    cmd_sel_n = 1'b1; dat_sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic strobe_wr(input bit to_cmd, input logic [15:0] d, input int hold);
    wdata = d;
    if (to_cmd) cmd_sel_n = 1'b0; else dat_sel_n = 1'b0;
    wr_n = 1'b0;
    repeat (hold) @(posedge clk);
    #1 release_all();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic rd_chk(input logic [15:0] e, input string tag);
    dat_sel_n = 1'b0; rd_n = 1'b0;
    chk(0, e, tag);
    repeat (2) @(posedge clk);
    #1 release_all();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [15:0] c, input logic [15:0] d);
    strobe_wr(1'b1, c, 3);
    strobe_wr(1'b0, d, 3);
  endtask

  task automatic rd_reg(input logic [15:0] c, input logic [15:0] e, input string tag);
    strobe_wr(1'b1, c, 3);
    rd_chk(e, tag);
  endtask

  task automatic pulse_evt(input logic [15:0] v);
    evt_i = v;
    @(posedge clk); #1 evt_i = '0;
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk(1, 16'h0, "R1");
    chk(2, 16'h0, "R1");
    rd_chk(16'h0000, "R1");

    // R8 storage words, R2 lane placement
    wr_reg(16'h3010, 16'h1234);
    rd_reg(16'h3010, 16'h1234, "R8");
    wr_reg(16'hC012, 16'hABCD);
    rd_reg(16'hC012, 16'hABCD, "R2");
    wr_reg(16'h3012, 16'h5555);            // wrong lanes, ignored
    rd_reg(16'hC012, 16'hABCD, "R2");
    rd_reg(16'h3012, 16'h0000, "R2");
    rd_reg(16'h3011, 16'h0000, "R2");      // odd offset
    wr_reg(16'h3014, 16'h0F0F);
    rd_reg(16'h3014, 16'h0F0F, "R8");

    // R3 one access per command, R9 long strobe counts once
    strobe_wr(1'b1, 16'h3010, 3);
    dat_sel_n = 1'b0; rd_n = 1'b0;
    chk(0, 16'h1234, "R3");
    repeat (10) @(posedge clk);
    #1 release_all();
    repeat (4) @(posedge clk); #1;
    rd_chk(16'h0000, "R3");
    strobe_wr(1'b0, 16'h9999, 3);
    rd_reg(16'h3010, 16'h1234, "R3");

    // R4 identification
    rd_reg(16'h30C0, 16'h8872, "R4");
    wr_reg(16'h30C0, 16'hFFFF);
    rd_reg(16'h30C0, 16'h8872, "R4");

    // R5 soft reset
    wr_reg(16'hC026, 16'h00FF);
    chk(1, 16'h1, "R5");
    rd_reg(16'hC026, 16'h0001, "R5");
    chk(1, 16'h1, "R5");
    wr_reg(16'hC026, 16'h0000);
    chk(1, 16'h0, "R5");

    // R9 exact latency of a write
    strobe_wr(1'b1, 16'hC026, 3);
    wdata = 16'h0001; dat_sel_n = 1'b0; wr_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 release_all();
    @(posedge clk);
    @(posedge clk); #1;
    chk(1, 16'h0, "R9");
    chk(1, 16'h1, "R9");
    repeat (3) @(posedge clk); #1;
    wr_reg(16'hC026, 16'h0000);

    // R6 / R7 interrupt status and mask
    pulse_evt(16'h6000);
    rd_reg(16'hC092, 16'h6000, "R6");
    chk(2, 16'h0, "R7");
    wr_reg(16'h3090, 16'h2000);
    chk(2, 16'h1, "R7");
    wr_reg(16'hC092, 16'h2000);
    rd_reg(16'hC092, 16'h4000, "R6");
    chk(2, 16'h0, "R7");
    wr_reg(16'hC092, 16'h0000);
    rd_reg(16'hC092, 16'h4000, "R6");

    // R6 set wins over same-cycle clear
    strobe_wr(1'b1, 16'hC092, 3);
    wdata = 16'h4000; dat_sel_n = 1'b0; wr_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 release_all();
    @(posedge clk);
    @(posedge clk); #1 evt_i = 16'h4000;
    @(posedge clk); #1 evt_i = 16'h0000;
    repeat (2) @(posedge clk); #1;
    rd_reg(16'hC092, 16'h4000, "R6");
    wr_reg(16'hC092, 16'h4000);
    rd_reg(16'hC092, 16'h0000, "R6");

    wr_reg(16'h3090, 16'h6000);
    pulse_evt(16'h4000);
    chk(2, 16'h1, "R7");
    wr_reg(16'h3090, 16'h0000);
    chk(2, 16'h0, "R7");
    rd_reg(16'h3090, 16'h0000, "R7");

    // R8 unmapped offset
    wr_reg(16'h3050, 16'h7777);
    rd_reg(16'h3050, 16'h0000, "R8");

    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule